// File: doc/BRIEF.md
# Paged Address Translator with Per-Page Protection

This block turns a virtual address into a physical address through a small page table held inside the block. Every request carries a virtual address and an access kind: read, write or execute. The upper bits of the address select one table entry. That entry supplies a frame number, which is joined to the untouched low-order offset bits. The same entry also holds a valid flag and three permission flags. These are checked on every request. A request that targets an unmapped page, or that asks for an access the page does not grant, returns a fault code instead of an address.

Software fills the table through a single-cycle configuration write port. The port takes an entry index, a frame number and a protection nibble. A reset wipes every entry to invalid. Until the table is programmed, every request therefore faults. The result can be taken combinationally or from a register one cycle after the request; the default build registers it.

Top module: `pxl_translator`

## Requirements
- R1: For a permitted access, rsp_paddr equals the frame number of the entry selected by the virtual page number (address bits above the offset), concatenated with the unchanged offset; with the default sizes, table frames [2,5,1,8] and virtual address 241 give 561.
- R2: A request to an entry whose valid flag is clear returns rsp_fault = 2'b01 with rsp_paddr = 0.
- R3: A request to a valid entry whose permission flag for the requested kind is clear returns rsp_fault = 2'b10 with rsp_paddr = 0; an invalid entry reports 2'b01 even when its permission flags are set.
- R4: The protection nibble is cfg_prot[3]=valid, [2]=read, [1]=write, [0]=execute. The access kind encodings are req_kind 2'b00 = read, 2'b01 = write and 2'b10 = execute. Each kind is gated only by its own flag.
- R5: Reset clears every entry to invalid, both at power-up and when it is asserted again after programming.
- R6: A configuration write is seen by requests from the following clock cycle. A request in the same cycle as the write sees the old entry contents.
- R7: In the registered build, rsp_valid goes high exactly one cycle after req_valid. While rsp_valid is low, rsp_paddr and rsp_fault are zero.
- R8: The reserved access kind 2'b11 is refused as a permission fault (2'b10) on a valid page.
- R9: A configuration write changes only the entry at cfg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears table and response |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | VA_W-OFF_W | Entry index to write |
| cfg_pfn | input | PA_W-OFF_W | Frame number to store |
| cfg_prot | input | 4 | Protection nibble {valid, read, write, execute} |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | PA_W | Physical address, zero on a fault |
| rsp_fault | output | 2 | 00 none, 01 invalid page, 10 permission refused |

## Verification
The bench first checks the worked example at the largest page number and at both offset extremes. A design that shifted or truncated the frame field would return an address other than 561. Each single-permission page is tried with all three access kinds. A swapped flag position therefore shows up as a fault on the wrong kind. An invalid page that grants every permission must still report the invalid code; a design with the wrong priority would report a permission fault there. Other runs target a write and a lookup in the same cycle, a write that could leak into a neighbouring entry, the reserved access kind, and a reset asserted again after programming. A design that forwarded writes, decoded the index badly, accepted the reserved kind or left entries alive after reset would show the new frame too early, corrupt another page, return an address, or translate where it should fault.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
   // access kind encodings
   localparam logic [1:0] KIND_READ  = 2'b00;
   localparam logic [1:0] KIND_WRITE = 2'b01;
   localparam logic [1:0] KIND_EXEC  = 2'b10;

   // fault encodings
   localparam logic [1:0] FLT_NONE    = 2'b00;
   localparam logic [1:0] FLT_INVALID = 2'b01;
   localparam logic [1:0] FLT_PERM    = 2'b10;

   // protection nibble bit positions
   localparam int PROT_V = 3;
   localparam int PROT_R = 2;
   localparam int PROT_W = 1;
   localparam int PROT_X = 0;
   localparam int PROT_BITS = 4;
endpackage

// File: rtl/pxl_split.sv
module pxl_split #(
   parameter int VA_W  = 8,
   parameter int OFF_W = 6,
   localparam int VPN_W = VA_W - OFF_W
) (
   input  logic [VA_W-1:0]  vaddr,
   output logic [VPN_W-1:0] vpn,
   output logic [OFF_W-1:0] off
);
   assign vpn = vaddr[VA_W-1:OFF_W];
   assign off = vaddr[OFF_W-1:0];
endmodule

// File: rtl/pxl_table.sv
module pxl_table
   import pxl_pkg::*;
#(
   parameter int VPN_W = 2,
   parameter int PFN_W = 4,
   localparam int N_ENT = 1 << VPN_W,
   localparam int ENT_W = PFN_W + PROT_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [VPN_W-1:0]     wr_idx,
   input  logic [PFN_W-1:0]     wr_pfn,
   input  logic [PROT_BITS-1:0] wr_prot,
   input  logic [VPN_W-1:0]     rd_idx,
   output logic [PFN_W-1:0]     rd_pfn,
   output logic [PROT_BITS-1:0] rd_prot
);
   logic [ENT_W-1:0] ent_q [N_ENT];

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_idx == VPN_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   ent_q[g] <= '0;
         else if (hit) ent_q[g] <= {wr_prot, wr_pfn};
      end
   end

   assign rd_pfn  = ent_q[rd_idx][PFN_W-1:0];
   assign rd_prot = ent_q[rd_idx][ENT_W-1:PFN_W];
endmodule

// File: rtl/pxl_check.sv
module pxl_check
   import pxl_pkg::*;
(
   input  logic [PROT_BITS-1:0] prot,
   input  logic [1:0]           kind,
   output logic [1:0]           fault
);
   logic allowed;

   always_comb begin
      unique case (kind)
         KIND_READ:  allowed = prot[PROT_R];
         KIND_WRITE: allowed = prot[PROT_W];
         KIND_EXEC:  allowed = prot[PROT_X];
         default:    allowed = 1'b0;
      endcase
   end

   always_comb begin
      if (!prot[PROT_V])  fault = FLT_INVALID;
      else if (!allowed)  fault = FLT_PERM;
      else                fault = FLT_NONE;
   end
endmodule

// File: rtl/pxl_translator.sv
module pxl_translator
   import pxl_pkg::*;
#(
   parameter int VA_W    = 8,
   parameter int PA_W    = 10,
   parameter int OFF_W   = 6,
   parameter bit REG_OUT = 1'b1,
   localparam int VPN_W  = VA_W - OFF_W,
   localparam int PFN_W  = PA_W - OFF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [VA_W-1:0]      req_vaddr,
   input  logic [1:0]           req_kind,
   input  logic                 cfg_we,
   input  logic [VPN_W-1:0]     cfg_idx,
   input  logic [PFN_W-1:0]     cfg_pfn,
   input  logic [PROT_BITS-1:0] cfg_prot,
   output logic                 rsp_valid,
   output logic [PA_W-1:0]      rsp_paddr,
   output logic [1:0]           rsp_fault
);
   if (OFF_W < 1 || OFF_W >= VA_W) begin : g_bad_off
      $error("pxl_translator: OFF_W must lie in 1..VA_W-1");
   end
   if (PA_W <= OFF_W) begin : g_bad_pa
      $error("pxl_translator: PA_W must exceed OFF_W");
   end
   if (VPN_W > 10) begin : g_bad_vpn
      $error("pxl_translator: table too large for flop storage");
   end

   logic [VPN_W-1:0]     vpn;
   logic [OFF_W-1:0]     off;
   logic [PFN_W-1:0]     pfn;
   logic [PROT_BITS-1:0] prot;
   logic [1:0]           fault_c;
   logic                 nxt_valid;
   logic [PA_W-1:0]      nxt_paddr;
   logic [1:0]           nxt_fault;

   pxl_split #(.VA_W(VA_W), .OFF_W(OFF_W)) u_split (
      .vaddr (req_vaddr),
      .vpn   (vpn),
      .off   (off)
   );

   pxl_table #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_idx  (cfg_idx),
      .wr_pfn  (cfg_pfn),
      .wr_prot (cfg_prot),
      .rd_idx  (vpn),
      .rd_pfn  (pfn),
      .rd_prot (prot)
   );

   pxl_check u_check (
      .prot  (prot),
      .kind  (req_kind),
      .fault (fault_c)
   );

   always_comb begin
      nxt_valid = req_valid;
      nxt_fault = req_valid ? fault_c : FLT_NONE;
      nxt_paddr = (req_valid && fault_c == FLT_NONE) ? {pfn, off} : '0;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
         end else begin
            rsp_valid <= nxt_valid;
            rsp_paddr <= nxt_paddr;
            rsp_fault <= nxt_fault;
         end
      end
   end else begin : g_comb
      assign rsp_valid = nxt_valid;
      assign rsp_paddr = nxt_paddr;
      assign rsp_fault = nxt_fault;
   end
endmodule

// File: rtl/pxl_translator_chk.sv
module pxl_translator_chk #(
   parameter int VA_W    = 8,
   parameter int PA_W    = 10,
   parameter bit REG_OUT = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic [1:0]      req_kind,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_paddr,
   input logic [1:0]      rsp_fault
);
   // R2 R3: a faulting response never carries an address
   p_fault_zero_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault != 2'b00) |-> (rsp_paddr == '0));

   // R3: only the defined fault codes appear
   p_fault_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault != 2'b11);

   // R7: outputs idle when no response
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_paddr == '0 && rsp_fault == 2'b00));

   if (REG_OUT) begin : g_reg_chk
      // R7: response strobe trails request by one cycle
      p_rsp_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);
      p_rsp_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !rsp_valid);
      // R8: the reserved kind never translates
      p_reserved_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_kind == 2'b11) |=> (rsp_fault != 2'b00));
   end

   logic unused_ok;
   assign unused_ok = ^req_vaddr;
endmodule

bind pxl_translator pxl_translator_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_vaddr (req_vaddr),
   .req_kind  (req_kind),
   .rsp_valid (rsp_valid),
   .rsp_paddr (rsp_paddr),
   .rsp_fault (rsp_fault)
);

// File: tb/tb_pxl_translator.sv
module tb_pxl_translator;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_vaddr = '0;
   logic [1:0] req_kind = '0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_idx = '0;
   logic [3:0] cfg_pfn = '0;
   logic [3:0] cfg_prot = '0;
   logic       rsp_valid;
   logic [9:0] rsp_paddr;
   logic [1:0] rsp_fault;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   pxl_translator dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_pfn(cfg_pfn),
      .cfg_prot(cfg_prot), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_ent(input logic [1:0] idx, input logic [3:0] pfn, input logic [3:0] prot);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_pfn = pfn; cfg_prot = prot;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // drive at negedge, result registered at next posedge, sample at following negedge
   task automatic lookup(input logic [7:0] va, input logic [1:0] kind,
                         input logic [9:0] ep, input logic [1:0] ef, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_kind = kind;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, 16'(rsp_valid), 16'd1);
      check({req, " paddr"}, 16'(rsp_paddr), 16'(ep));
      check({req, " fault"}, 16'(rsp_fault), 16'(ef));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R7 reset valid", 16'(rsp_valid), 16'd0);
      check("R7 reset paddr", 16'(rsp_paddr), 16'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset();
      for (int p = 0; p < 4; p++) lookup(8'(p * 64 + 5), 2'b00, 10'd0, 2'b01, "R5 after reset");
   endtask

   task automatic t_example();
      write_ent(2'd0, 4'd2, 4'b1111);
      write_ent(2'd1, 4'd5, 4'b1111);
      write_ent(2'd2, 4'd1, 4'b1111);
      write_ent(2'd3, 4'd8, 4'b1111);
      lookup(8'd241, 2'b00, 10'd561, 2'b00, "R1 va241");
      lookup(8'd0,   2'b01, 10'd128, 2'b00, "R1 va0");
      lookup(8'd127, 2'b10, 10'd383, 2'b00, "R1 va127");
      lookup(8'd128, 2'b00, 10'd64,  2'b00, "R1 va128");
   endtask

   task automatic t_perms();
      write_ent(2'd0, 4'd3, 4'b1100);
      write_ent(2'd1, 4'd6, 4'b1010);
      write_ent(2'd2, 4'd7, 4'b1001);
      lookup(8'd10, 2'b00, 10'd202, 2'b00, "R4 read-only read");
      lookup(8'd10, 2'b01, 10'd0,   2'b10, "R3 read-only write");
      lookup(8'd10, 2'b10, 10'd0,   2'b10, "R3 read-only exec");
      lookup(8'd70, 2'b00, 10'd0,   2'b10, "R3 write-only read");
      lookup(8'd70, 2'b01, 10'd390, 2'b00, "R4 write-only write");
      lookup(8'd70, 2'b10, 10'd0,   2'b10, "R3 write-only exec");
      lookup(8'd130, 2'b00, 10'd0,   2'b10, "R3 exec-only read");
      lookup(8'd130, 2'b01, 10'd0,   2'b10, "R3 exec-only write");
      lookup(8'd130, 2'b10, 10'd450, 2'b00, "R4 exec-only exec");
   endtask

   task automatic t_invalid();
      write_ent(2'd3, 4'd9, 4'b0111);
      lookup(8'd200, 2'b00, 10'd0, 2'b01, "R2 invalid read");
      lookup(8'd200, 2'b10, 10'd0, 2'b01, "R3 invalid precedence");
   endtask

   task automatic t_reserved();
      write_ent(2'd3, 4'd9, 4'b1111);
      lookup(8'd200, 2'b11, 10'd0, 2'b10, "R8 reserved kind");
      lookup(8'd200, 2'b00, 10'd584, 2'b00, "R8 same page read");
   endtask

   task automatic t_same_cycle();
      // page 3 holds frame 9 full access; rewrite to frame 4 while looking up
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 2'd3; cfg_pfn = 4'd4; cfg_prot = 4'b1111;
      req_valid = 1'b1; req_vaddr = 8'd193; req_kind = 2'b00;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      check("R6 same-cycle old paddr", 16'(rsp_paddr), 16'd577);
      lookup(8'd193, 2'b00, 10'd257, 2'b00, "R6 next-cycle new paddr");
   endtask

   task automatic t_isolation();
      write_ent(2'd2, 4'd15, 4'b1111);
      lookup(8'd10,  2'b00, 10'd202, 2'b00, "R9 entry0 kept");
      lookup(8'd70,  2'b01, 10'd390, 2'b00, "R9 entry1 kept");
      lookup(8'd193, 2'b00, 10'd257, 2'b00, "R9 entry3 kept");
      lookup(8'd191, 2'b00, 10'd1023, 2'b00, "R9 entry2 new");
   endtask

   task automatic t_idle();
      @(negedge clk);
      check("R7 idle valid", 16'(rsp_valid), 16'd0);
      check("R7 idle paddr", 16'(rsp_paddr), 16'd0);
      check("R7 idle fault", 16'(rsp_fault), 16'd0);
   endtask

   task automatic t_rereset();
      do_reset();
      lookup(8'd10,  2'b00, 10'd0, 2'b01, "R5 re-reset entry0");
      lookup(8'd191, 2'b00, 10'd0, 2'b01, "R5 re-reset entry2");
   endtask

   task automatic run_all();
      t_reset_state();
      t_example();
      t_perms();
      t_invalid();
      t_reserved();
      t_same_cycle();
      t_isolation();
      t_idle();
      t_rereset();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish");
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule